// File: doc/BRIEF.md
# Boot Command Sequencer with Sector Addressing

This block sits at the front of a flash controller and handles the boot-area command path. A host writes words over a simple synchronous register bus. Two small address windows accept single-word boot commands. The block also holds eight 16-bit start-address registers and a start-buffer register. The start-buffer register holds a buffer index and a sector count.

Three command words are understood. One asks for a warm reset, one asks for identification readback, and one arms a page load. When armed, a following boot write of zero starts a full-page load. The block then works out a linear 512-byte sector number from the block register (slot 0) and the page register (slot 7). It presents that number to a page-load engine over a request/acknowledge handshake. After each such load the page register steps forward by four sectors, modulo 256, so a host can stream consecutive pages. A density option folds bit 15 of the block register into one upper block bit.

The warm-reset and identification commands come out as one-cycle strobes. Data movement is handled elsewhere.

Top module: `boot_cmd_sequencer`

## Requirements
- R1: After the reset input is released, every start-address register reads 0, the start-buffer register reads 0, load_req is low, and both strobes are low.
- R2: A bus write to address SA_BASE+i (i = 0..7, default 0xF100) stores the full 16-bit word in start-address register i. Reading that address returns the stored word combinationally on bus_rdata.
- R3: A write to SB_ADDR (default 0xF200) takes the buffer index from bits 11:8 and the sector count from bits 1:0, where the value 0 means 4. Reading it returns (index << 8) | ((count - 1) & 2).
- R4: A load request carries sector = {blk, page[7:0]}, where page is register 7 and blk is register 0 bits 11:0. When DENS_EN is set and register 0 bit 15 is 1, blk is ORed with 1 << (6 + SIZE_CODE). load_count is always 4 while load_req is high.
- R5: Boot commands are accepted only at addresses 0x0000–0x01FF and 0x8000–0x800F. Writes elsewhere, other than to the registers, have no effect.
- R6: An unarmed boot write of 0x00F0 gives a one-cycle warm_rst_o pulse. It also returns the registers, the armed state and any deferred trigger to their reset values.
- R7: An unarmed boot write of 0x0090 gives a one-cycle ident_o pulse and changes no register.
- R8: An unarmed boot write of 0x00E0 arms the block. The next boot write always disarms it. That write starts a load only if it is 0x0000, and it is never decoded as a command. When the load is issued, the page register becomes (page + 4) & 0xFF.
- R9: load_req stays high, with load_sector unchanged, until load_ack is sampled high. It is low in the following cycle.
- R10: A trigger that arrives while a request is outstanding is held, with at most one held at a time. It is issued in the cycle after the acknowledge, using the register contents at that moment.
- R11: Other boot values, and 0x0000 without arming, cause no request, no strobe and no register change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 16 | Word address for writes and reads |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data for bus_addr |
| load_req | output | 1 | Page-load request, held until acknowledged |
| load_sector | output | SECT_W | Linear sector number of the request |
| load_count | output | 3 | Sectors to load (always 4) |
| load_ack | input | 1 | Acknowledge from the page-load engine |
| warm_rst_o | output | 1 | One-cycle warm-reset strobe |
| ident_o | output | 1 | One-cycle identification strobe |

## Verification
The assertions check the handshake rules on every cycle: the request is held and its sector frozen until acknowledged, the request drops after an acknowledge, and the count stays at four. They also check, at each issued request, that the sector's low byte matches the page register and that the page register stepped by four with its upper byte cleared. Only the bench scenarios can show the decoding results. These cover the density fold into the block bits, the two boot windows and their edges, the disarming effect of an armed non-zero write (including an armed 0x00F0 that must not reset), the start-buffer readback encoding, and the deferred trigger being issued with the then-current address.

// File: rtl/bootseq_pkg.sv
package bootseq_pkg;
   localparam logic [15:0] CMD_WARM  = 16'h00F0;
   localparam logic [15:0] CMD_IDENT = 16'h0090;
   localparam logic [15:0] CMD_ARM   = 16'h00E0;
   localparam logic [15:0] CMD_FIRE  = 16'h0000;
   localparam int NUM_SA   = 8;
   localparam int BLK_SLOT = 0;
   localparam int PAGE_SLOT = 7;
   localparam logic [2:0] FULL_PAGE = 3'd4;

   typedef enum logic [1:0] {
      WIN_NONE,
      WIN_BOOT,
      WIN_SADDR,
      WIN_SBUF
   } win_e;
endpackage

// File: rtl/bootseq_window_dec.sv
module bootseq_window_dec
   import bootseq_pkg::*;
#(
   parameter logic [15:0] LO_END  = 16'h01FF,
   parameter logic [15:0] HI_BASE = 16'h8000,
   parameter logic [15:0] HI_END  = 16'h800F,
   parameter logic [15:0] SA_BASE = 16'hF100,
   parameter logic [15:0] SB_ADDR = 16'hF200
) (
   input  logic [15:0] addr,
   output win_e        kind,
   output logic [2:0]  slot
);
   logic in_lo, in_hi, in_sa;

   always_comb begin
      in_lo = (addr <= LO_END);
      in_hi = (addr >= HI_BASE) && (addr <= HI_END);
      in_sa = (addr[15:3] == SA_BASE[15:3]);
      slot  = addr[2:0];
      if (in_lo || in_hi)        kind = WIN_BOOT;
      else if (in_sa)            kind = WIN_SADDR;
      else if (addr == SB_ADDR)  kind = WIN_SBUF;
      else                       kind = WIN_NONE;
   end
endmodule

// File: rtl/bootseq_sector_map.sv
module bootseq_sector_map #(
   parameter int SIZE_CODE = 3,
   parameter bit DENS_EN   = 1'b1,
   parameter int BLK_W     = 12,
   parameter int SECT_W    = 20
) (
   input  logic [15:0]       blk_reg,
   input  logic [15:0]       page_reg,
   output logic [SECT_W-1:0] sector
);
   localparam logic [BLK_W-1:0] ONE_B   = {{(BLK_W-1){1'b0}}, 1'b1};
   localparam logic [BLK_W-1:0] D_MASK  = ONE_B << (6 + SIZE_CODE);

   logic [BLK_W-1:0] blk_base;
   logic [BLK_W-1:0] blk_eff;
   logic             unused_bits;

   assign blk_base    = {{(BLK_W-12){1'b0}}, blk_reg[11:0]};
   assign unused_bits = ^{blk_reg[15:12], page_reg[15:8]};

   generate
      if (DENS_EN) begin : g_fold
         assign blk_eff = blk_base | (blk_reg[15] ? D_MASK : '0);
      end else begin : g_plain
         assign blk_eff = blk_base;
      end
   endgenerate

   assign sector = {blk_eff, page_reg[7:0]};
endmodule

// File: rtl/bootseq_cmd_fsm.sv
module bootseq_cmd_fsm
   import bootseq_pkg::*;
#(
   parameter int SECT_W = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              boot_wr,
   input  logic [15:0]       boot_val,
   input  logic [SECT_W-1:0] sector_in,
   input  logic              ack,
   output logic              rst_cmd,
   output logic              advance,
   output logic              req_q,
   output logic [SECT_W-1:0] sector_q,
   output logic              warm_q,
   output logic              ident_q
);
   logic armed_q, pend_q;
   logic id_cmd, fire, issue;

   always_comb begin
      rst_cmd = boot_wr && !armed_q && (boot_val == CMD_WARM);
      id_cmd  = boot_wr && !armed_q && (boot_val == CMD_IDENT);
      fire    = boot_wr && armed_q && (boot_val == CMD_FIRE);
      issue   = (fire || pend_q) && !req_q && !rst_cmd;
      advance = issue;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q  <= 1'b0;
         pend_q   <= 1'b0;
         req_q    <= 1'b0;
         sector_q <= '0;
         warm_q   <= 1'b0;
         ident_q  <= 1'b0;
      end else begin
         warm_q  <= rst_cmd;
         ident_q <= id_cmd;
         if (boot_wr) begin
            armed_q <= armed_q ? 1'b0 : (boot_val == CMD_ARM);
         end
         if (rst_cmd)            pend_q <= 1'b0;
         else if (issue)         pend_q <= 1'b0;
         else if (fire && req_q) pend_q <= 1'b1;
         if (issue) begin
            req_q    <= 1'b1;
            sector_q <= sector_in;
         end else if (req_q && ack) begin
            req_q <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/boot_cmd_sequencer.sv
module boot_cmd_sequencer
   import bootseq_pkg::*;
#(
   parameter int          SIZE_CODE = 3,
   parameter bit          DENS_EN   = 1'b1,
   parameter int          SECT_W    = 20,
   parameter logic [15:0] SA_BASE   = 16'hF100,
   parameter logic [15:0] SB_ADDR   = 16'hF200
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [15:0]       bus_addr,
   input  logic [15:0]       bus_wdata,
   output logic [15:0]       bus_rdata,
   output logic              load_req,
   output logic [SECT_W-1:0] load_sector,
   output logic [2:0]        load_count,
   input  logic              load_ack,
   output logic              warm_rst_o,
   output logic              ident_o
);
   localparam int BLK_W = ((7 + SIZE_CODE) > 12) ? (7 + SIZE_CODE) : 12;

   generate
      if (SIZE_CODE < 0 || SIZE_CODE > 7) begin : g_bad_size
         $error("SIZE_CODE must be 0..7");
      end
      if (SECT_W != BLK_W + 8) begin : g_bad_sect
         $error("SECT_W must equal block width plus 8");
      end
   endgenerate

   win_e        kind;
   logic [2:0]  slot;
   logic [15:0] addr_q [NUM_SA];
   logic [3:0]  buf_q;
   logic [2:0]  cnt_q;
   logic [2:0]  cnt_m1;
   logic [15:0] page_q;
   logic [SECT_W-1:0] sector_c;
   logic        rst_cmd, advance, sa_wr, sb_wr;

   bootseq_window_dec #(
      .SA_BASE (SA_BASE),
      .SB_ADDR (SB_ADDR)
   ) win_i (
      .addr (bus_addr),
      .kind (kind),
      .slot (slot)
   );

   bootseq_sector_map #(
      .SIZE_CODE (SIZE_CODE),
      .DENS_EN   (DENS_EN),
      .BLK_W     (BLK_W),
      .SECT_W    (SECT_W)
   ) map_i (
      .blk_reg  (addr_q[BLK_SLOT]),
      .page_reg (addr_q[PAGE_SLOT]),
      .sector   (sector_c)
   );

   bootseq_cmd_fsm #(
      .SECT_W (SECT_W)
   ) fsm_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .boot_wr   (bus_wr && (kind == WIN_BOOT)),
      .boot_val  (bus_wdata),
      .sector_in (sector_c),
      .ack       (load_ack),
      .rst_cmd   (rst_cmd),
      .advance   (advance),
      .req_q     (load_req),
      .sector_q  (load_sector),
      .warm_q    (warm_rst_o),
      .ident_q   (ident_o)
   );

   assign sa_wr  = bus_wr && (kind == WIN_SADDR);
   assign sb_wr  = bus_wr && (kind == WIN_SBUF);
   assign page_q = addr_q[PAGE_SLOT];
   assign load_count = FULL_PAGE;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_SA; i++) addr_q[i] <= '0;
         buf_q <= '0;
         cnt_q <= 3'd1;
      end else if (rst_cmd) begin
         for (int i = 0; i < NUM_SA; i++) addr_q[i] <= '0;
         buf_q <= '0;
         cnt_q <= 3'd1;
      end else begin
         for (int i = 0; i < NUM_SA; i++) begin
            if (sa_wr && (slot == 3'(i))) begin
               addr_q[i] <= bus_wdata;
            end else if ((i == PAGE_SLOT) && advance) begin
               addr_q[i] <= {8'h00, addr_q[i][7:0] + 8'd4};
            end
         end
         if (sb_wr) begin
            buf_q <= bus_wdata[11:8];
            cnt_q <= (bus_wdata[1:0] == 2'b00) ? 3'd4 : {1'b0, bus_wdata[1:0]};
         end
      end
   end

   assign cnt_m1 = cnt_q - 3'd1;

   always_comb begin
      case (kind)
         WIN_SADDR: bus_rdata = addr_q[slot];
         WIN_SBUF:  bus_rdata = {4'h0, buf_q, 6'h00, cnt_m1[1], 1'b0};
         default:   bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/boot_cmd_sequencer_chk.sv
module boot_cmd_sequencer_chk #(
   parameter int SECT_W = 20
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [15:0]       bus_addr,
   input logic              load_req,
   input logic              load_ack,
   input logic [SECT_W-1:0] load_sector,
   input logic [2:0]        load_count,
   input logic              warm_rst_o,
   input logic              ident_o,
   input logic [15:0]       page_q
);
   assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      load_req && !load_ack |=> load_req);

   assert_sector_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
      load_req && !load_ack |=> $stable(load_sector));

   assert_drop_after_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
      load_req && load_ack |=> !load_req);

   assert_full_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
      load_req |-> load_count == 3'd4);

   assert_sector_page_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(load_req) |-> load_sector[7:0] == $past(page_q[7:0]));

   assert_page_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(load_req) && !$past(bus_wr && bus_addr == 16'hF107)
      |-> page_q == {8'h00, $past(page_q[7:0]) + 8'd4});

   assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({warm_rst_o, ident_o}));
endmodule

bind boot_cmd_sequencer boot_cmd_sequencer_chk #(.SECT_W(SECT_W)) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_wr      (bus_wr),
   .bus_addr    (bus_addr),
   .load_req    (load_req),
   .load_ack    (load_ack),
   .load_sector (load_sector),
   .load_count  (load_count),
   .warm_rst_o  (warm_rst_o),
   .ident_o     (ident_o),
   .page_q      (page_q)
);

// File: tb/boot_cmd_sequencer_tb.sv
`timescale 1ns/1ps
module boot_cmd_sequencer_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [15:0] bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        load_req;
   logic [19:0] load_sector;
   logic [2:0]  load_count;
   logic        load_ack = 1'b0;
   logic        warm_rst_o, ident_o;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #2 clk = ~clk;

   boot_cmd_sequencer dut_i (
      .clk (clk), .rst_n (rst_n), .bus_wr (bus_wr), .bus_addr (bus_addr),
      .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .load_req (load_req),
      .load_sector (load_sector), .load_count (load_count), .load_ack (load_ack),
      .warm_rst_o (warm_rst_o), .ident_o (ident_o)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic bw(input logic [15:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [15:0] a, output logic [15:0] v);
      bus_addr = a;
      #0.5;
      v = bus_rdata;
   endtask

   task automatic do_ack();
      @(negedge clk);
      load_ack = 1'b1;
      @(negedge clk);
      load_ack = 1'b0;
   endtask

   task automatic t_reset();
      logic [15:0] v;
      for (int i = 0; i < 8; i++) begin
         rd(16'hF100 + 16'(i), v);
         chk("R1 addr reg", v, 0);
      end
      rd(16'hF200, v); chk("R1 start buffer", v, 0);
      chk("R1 req", load_req, 0);
      chk("R1 strobes", {warm_rst_o, ident_o}, 0);
   endtask

   task automatic t_regs();
      logic [15:0] v;
      for (int i = 0; i < 8; i++) bw(16'hF100 + 16'(i), 16'h1111 * 16'(i + 1));
      for (int i = 0; i < 8; i++) begin
         rd(16'hF100 + 16'(i), v);
         chk("R2 addr reg", v, 16'h1111 * 16'(i + 1));
      end
   endtask

   task automatic t_startbuf();
      logic [15:0] v;
      bw(16'hF200, 16'h0A03); rd(16'hF200, v); chk("R3 count3", v, 16'h0A02);
      bw(16'hF200, 16'h0500); rd(16'hF200, v); chk("R3 count0->4", v, 16'h0502);
      bw(16'hF200, 16'h0F01); rd(16'hF200, v); chk("R3 count1", v, 16'h0F00);
      bw(16'hF200, 16'hF302); rd(16'hF200, v); chk("R3 count2", v, 16'h0300);
   endtask

   task automatic t_load_basic();
      logic [15:0] v;
      bw(16'hF100, 16'h0ABC);
      bw(16'hF107, 16'h0009);
      bw(16'h0000, 16'h00E0);
      chk("R8 armed no req", load_req, 0);
      bw(16'h0000, 16'h0000);
      chk("R8 req", load_req, 1);
      chk("R4 sector", load_sector, 20'hABC09);
      chk("R4 count", load_count, 4);
      rd(16'hF107, v); chk("R8 page advance", v, 16'h000D);
      repeat (3) @(negedge clk);
      chk("R9 held", load_req, 1);
      chk("R9 sector stable", load_sector, 20'hABC09);
      do_ack();
      chk("R9 dropped", load_req, 0);
   endtask

   task automatic t_density();
      bw(16'hF100, 16'h8005);
      bw(16'hF107, 16'h0013);
      bw(16'h8003, 16'h00E0);
      bw(16'h0100, 16'h0000);
      chk("R4 density fold", load_sector, 20'h20513);
      do_ack();
   endtask

   task automatic t_wrap();
      logic [15:0] v;
      bw(16'hF100, 16'h0001);
      bw(16'hF107, 16'h12FC);
      bw(16'h0000, 16'h00E0);
      bw(16'h0000, 16'h0000);
      chk("R4 sector wrap", load_sector, 20'h001FC);
      rd(16'hF107, v); chk("R8 page wrap", v, 16'h0000);
      do_ack();
   endtask

   task automatic t_window();
      logic [15:0] v;
      bw(16'hF107, 16'h0020);
      bw(16'h0200, 16'h00E0);
      bw(16'h0200, 16'h0000);
      chk("R5 outside low window", load_req, 0);
      bw(16'h8010, 16'h0090);
      chk("R5 outside high window", ident_o, 0);
      bw(16'h800F, 16'h00E0);
      bw(16'h01FF, 16'h0000);
      chk("R5 window edges", load_req, 1);
      rd(16'hF107, v); chk("R5 page after edge load", v, 16'h0024);
      do_ack();
   endtask

   task automatic t_unknown();
      logic [15:0] v;
      bw(16'hF107, 16'h0010);
      bw(16'h0000, 16'h0000);
      chk("R11 fire unarmed", load_req, 0);
      bw(16'h0004, 16'h1234);
      chk("R11 unknown strobes", {warm_rst_o, ident_o, load_req}, 0);
      bw(16'h0000, 16'h00E0);
      bw(16'h0000, 16'h0055);
      bw(16'h0000, 16'h0000);
      chk("R8 disarmed by other value", load_req, 0);
      rd(16'hF107, v); chk("R11 page unchanged", v, 16'h0010);
   endtask

   task automatic t_armed_warm();
      logic [15:0] v;
      bw(16'hF103, 16'h7777);
      bw(16'h0000, 16'h00E0);
      bw(16'h0000, 16'h00F0);
      chk("R8 armed F0 no reset", warm_rst_o, 0);
      rd(16'hF103, v); chk("R8 armed F0 keeps regs", v, 16'h7777);
   endtask

   task automatic t_warm();
      logic [15:0] v;
      bw(16'hF200, 16'h0A03);
      bw(16'h8000, 16'h00F0);
      chk("R6 warm pulse", warm_rst_o, 1);
      chk("R6 no ident", ident_o, 0);
      rd(16'hF103, v); chk("R6 regs cleared", v, 0);
      rd(16'hF200, v); chk("R6 start buffer cleared", v, 0);
      @(negedge clk);
      chk("R6 pulse one cycle", warm_rst_o, 0);
   endtask

   task automatic t_ident();
      logic [15:0] v;
      bw(16'hF100, 16'h0042);
      bw(16'h0000, 16'h0090);
      chk("R7 ident pulse", ident_o, 1);
      chk("R7 no warm", warm_rst_o, 0);
      rd(16'hF100, v); chk("R7 regs kept", v, 16'h0042);
      @(negedge clk);
      chk("R7 pulse one cycle", ident_o, 0);
   endtask

   task automatic t_defer();
      logic [15:0] v;
      bw(16'hF100, 16'h0003);
      bw(16'hF107, 16'h0040);
      bw(16'h0000, 16'h00E0);
      bw(16'h0000, 16'h0000);
      chk("R10 first sector", load_sector, 20'h00340);
      bw(16'h0000, 16'h00E0);
      bw(16'h0000, 16'h0000);
      chk("R10 held while busy", load_sector, 20'h00340);
      rd(16'hF107, v); chk("R10 page not yet advanced", v, 16'h0044);
      bw(16'hF100, 16'h0007);
      @(negedge clk);
      load_ack = 1'b1;
      @(negedge clk);
      load_ack = 1'b0;
      chk("R10 gap after ack", load_req, 0);
      @(negedge clk);
      chk("R10 deferred issued", load_req, 1);
      chk("R10 deferred sector", load_sector, 20'h00744);
      rd(16'hF107, v); chk("R10 page advanced", v, 16'h0048);
      do_ack();
      repeat (2) @(negedge clk);
      chk("R10 only one held", load_req, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_regs();
      t_startbuf();
      t_load_basic();
      t_density();
      t_wrap();
      t_window();
      t_unknown();
      t_armed_warm();
      t_warm();
      t_ident();
      t_defer();
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule